// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block produces the second operand of a data-processing unit together with a shifter carry-out. It has two modes. In register mode it takes a register value and applies one of four shift types: logical left, logical right, arithmetic right, or rotate right. The shift amount comes from one of two sources. The first is a 5-bit immediate. The second is the low byte of another register, so that amount can reach 255.

In immediate mode it expands a 12-bit field into a 32-bit constant. The low eight bits of the field are zero-extended and then rotated right by twice the 4-bit count held in the upper four bits. The carry-out follows the usual data-processing convention: it is the last bit shifted out, or the incoming carry flag when nothing moves.

The result and the carry are registered, so both appear one clock after the inputs are presented. There is no handshake. A new operand is formed on every cycle.

Top module: `op2_shifter`

## Requirements
- R1: While `rst` is high, `op2` and `carry_out` are 0 at each rising edge. Otherwise, both outputs reflect the inputs sampled at the previous rising edge (one cycle of latency).
- R2: Register mode with `shift_kind` = 2'b00 (logical left) and amount n in 1..31: `op2` = value << n, with zeros filling from the bottom. `carry_out` = value bit (32-n).
- R3: `shift_kind` = 2'b01 (logical right) with n in 1..31: `op2` = value >> n, with zeros filling from the top. `carry_out` = value bit (n-1).
- R4: `shift_kind` = 2'b10 (arithmetic right) with n in 1..31: vacated high bits are copies of value bit 31. `carry_out` = value bit (n-1).
- R5: `shift_kind` = 2'b11 (rotate right) with n nonzero: `op2` = value rotated right by n mod 32. `carry_out` = bit 31 of that result. The number of set bits in the result equals that of the value.
- R6: In register mode with an amount of 0, `op2` equals the register value and `carry_out` equals `carry_in`, for every shift type.
- R7: When `amt_from_reg` = 1, the amount is `amt_reg[7:0]` and bits 31:8 of `amt_reg` have no effect. When it is 0, the amount is `amt_imm`.
- R8: Logical left by exactly 32 gives 0 with carry = value bit 0. Logical right by exactly 32 gives 0 with carry = value bit 31. Either logical shift by 33..255 gives 0 with carry 0.
- R9: Arithmetic right by 32..255 gives 32 copies of value bit 31, and the carry is that same bit.
- R10: With `imm_mode` = 1, `op2` = zero-extended `imm_field[7:0]` rotated right by 2*`imm_field[11:8]`. For example, 0x4FF gives 0xFF000000 and 0xF01 gives 0x00000004.
- R11: In immediate mode, `carry_out` is bit 31 of the constant when `imm_field[11:8]` is nonzero. Otherwise it is `carry_in`.
- R12: In immediate mode, `reg_val`, `shift_kind`, `amt_from_reg`, `amt_imm` and `amt_reg` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imm_mode | input | 1 | 1 selects constant decode, 0 selects register shift |
| imm_field | input | 12 | Rotate count [11:8] and 8-bit value [7:0] |
| reg_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| amt_from_reg | input | 1 | 1 takes the amount from amt_reg[7:0] |
| amt_imm | input | 5 | Immediate shift amount |
| amt_reg | input | 32 | Register holding the shift amount in its low byte |
| carry_in | input | 1 | Current carry flag |
| op2 | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry-out |

## Verification
The embedded assertions check five properties on every cycle:
- a zero amount leaves the value and the carry unchanged;
- a constant with a zero rotate count passes through zero-extended with the incoming carry;
- wide logical left shifts clear the operand;
- wide arithmetic right shifts fill the operand with the sign bit;
- rotation preserves the number of set bits.

The exact bit placement and the carry bit chosen at amounts 1, 31, 32, 33 and 255 are shown only by the bench scenarios. So are the independence from the high bits of the amount register, the independence from register-mode inputs in immediate mode, and the decode of all 4096 immediate encodings. The bench compares each of these against a bit-serial reference model.

// File: rtl/op2_pkg.sv
`timescale 1ns/1ps
package op2_pkg;

    parameter int OP_W    = 32;              // operand width
    parameter int SH_W    = $clog2(OP_W);    // bits of a modulo-width amount
    parameter int AMT_W   = 8;               // register-sourced amount width
    parameter int IMMV_W  = 8;               // immediate constant payload
    parameter int IMMR_W  = 4;               // immediate rotate count
    parameter int FIELD_W = IMMR_W + IMMV_W; // whole immediate field

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic            carry;
        logic [OP_W-1:0] value;
    } op2_res_t;

    // true when a register-sourced amount reaches or passes the full width
    function automatic logic amt_is_wide(input logic [AMT_W-1:0] a);
        return a >= AMT_W'(OP_W);
    endfunction

endpackage

// File: rtl/op2_amount_sel.sv
`timescale 1ns/1ps
module op2_amount_sel
    import op2_pkg::*;
#(
    parameter int W   = OP_W,
    parameter int AW  = AMT_W,
    parameter int IAW = SH_W
) (
    input  logic          from_reg,
    input  logic [IAW-1:0] amt_imm,
    input  logic [W-1:0]  amt_reg,
    output logic [AW-1:0] amt
);
    // only the low byte of the amount register takes part
    logic unused_amt_hi;
    assign unused_amt_hi = ^amt_reg[W-1:AW];

    always_comb begin
        if (from_reg) amt = amt_reg[AW-1:0];
        else          amt = AW'(amt_imm);
    end
endmodule

// File: rtl/op2_rotator.sv
`timescale 1ns/1ps
module op2_rotator #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [SW+1];

    assign stg[0] = din;

    // one stage per amount bit, each rotating right by a power of two
    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int K = 1 << s;
        assign stg[s+1] = amt[s] ? {stg[s][K-1:0], stg[s][W-1:K]} : stg[s];
    end

    assign dout = stg[SW];
endmodule

// File: rtl/op2_reg_shift.sv
`timescale 1ns/1ps
module op2_reg_shift
    import op2_pkg::*;
#(
    parameter int W  = OP_W,
    parameter int SW = SH_W,
    parameter int AW = AMT_W
) (
    input  logic [W-1:0]  val,
    input  logic [1:0]    kind,
    input  logic [AW-1:0] amt,
    input  logic          cin,
    output op2_res_t      res
);
    localparam logic [AW-1:0] FULL = AW'(W);

    logic [SW-1:0] sh;
    logic [SW-1:0] lsl_idx;
    logic [SW-1:0] rsh_idx;
    logic          amt_zero;
    logic          amt_wide;
    logic          amt_full;
    logic [W-1:0]  rot;
    shift_kind_e   k;

    assign sh       = amt[SW-1:0];
    assign lsl_idx  = -sh;               // W - sh for sh in 1..W-1
    assign rsh_idx  = sh - SW'(1);       // sh - 1
    assign amt_zero = (amt == '0);
    assign amt_wide = amt_is_wide(amt);
    assign amt_full = (amt == FULL);
    assign k        = shift_kind_e'(kind);

    op2_rotator #(.W(W), .SW(SW)) u_rot (
        .din  (val),
        .amt  (sh),
        .dout (rot)
    );

    always_comb begin
        res.value = val;
        res.carry = cin;
        if (!amt_zero) begin
            unique case (k)
                SHK_LSL: begin
                    if (!amt_wide) begin
                        res.value = val << sh;
                        res.carry = val[lsl_idx];
                    end else begin
                        res.value = '0;
                        res.carry = amt_full ? val[0] : 1'b0;
                    end
                end
                SHK_LSR: begin
                    if (!amt_wide) begin
                        res.value = val >> sh;
                        res.carry = val[rsh_idx];
                    end else begin
                        res.value = '0;
                        res.carry = amt_full ? val[W-1] : 1'b0;
                    end
                end
                SHK_ASR: begin
                    if (!amt_wide) begin
                        res.value = W'($signed(val) >>> sh);
                        res.carry = val[rsh_idx];
                    end else begin
                        res.value = {W{val[W-1]}};
                        res.carry = val[W-1];
                    end
                end
                SHK_ROR: begin
                    res.value = rot;
                    res.carry = rot[W-1];
                end
                default: begin
                    res.value = val;
                    res.carry = cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/op2_imm_decode.sv
`timescale 1ns/1ps
module op2_imm_decode
    import op2_pkg::*;
#(
    parameter int W  = OP_W,
    parameter int SW = SH_W,
    parameter int VW = IMMV_W,
    parameter int RW = IMMR_W
) (
    input  logic [RW+VW-1:0] field,
    input  logic             cin,
    output op2_res_t         res
);
    logic [RW-1:0] cnt;
    logic [W-1:0]  ext;
    logic [SW-1:0] ramt;
    logic [W-1:0]  rot;

    assign cnt  = field[RW+VW-1:VW];
    assign ext  = W'(field[VW-1:0]);
    assign ramt = SW'({cnt, 1'b0});      // even rotation only

    op2_rotator #(.W(W), .SW(SW)) u_rot (
        .din  (ext),
        .amt  (ramt),
        .dout (rot)
    );

    always_comb begin
        res.value = rot;
        res.carry = (cnt != '0) ? rot[W-1] : cin;
    end
endmodule

// File: rtl/op2_shifter.sv
`timescale 1ns/1ps
module op2_shifter
    import op2_pkg::*;
#(
    parameter int W   = OP_W,
    parameter int SW  = SH_W,
    parameter int AW  = AMT_W,
    parameter int VW  = IMMV_W,
    parameter int RW  = IMMR_W,
    parameter int FW  = RW + VW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          imm_mode,
    input  logic [FW-1:0] imm_field,
    input  logic [W-1:0]  reg_val,
    input  logic [1:0]    shift_kind,
    input  logic          amt_from_reg,
    input  logic [SW-1:0] amt_imm,
    input  logic [W-1:0]  amt_reg,
    input  logic          carry_in,
    output logic [W-1:0]  op2,
    output logic          carry_out
);
    logic [AW-1:0] amt_sel;
    op2_res_t      reg_res;
    op2_res_t      imm_res;
    op2_res_t      nxt;
    logic          live_q;

    op2_amount_sel #(.W(W), .AW(AW), .IAW(SW)) u_amt (
        .from_reg (amt_from_reg),
        .amt_imm  (amt_imm),
        .amt_reg  (amt_reg),
        .amt      (amt_sel)
    );

    op2_reg_shift #(.W(W), .SW(SW), .AW(AW)) u_shift (
        .val  (reg_val),
        .kind (shift_kind),
        .amt  (amt_sel),
        .cin  (carry_in),
        .res  (reg_res)
    );

    op2_imm_decode #(.W(W), .SW(SW), .VW(VW), .RW(RW)) u_imm (
        .field (imm_field),
        .cin   (carry_in),
        .res   (imm_res)
    );

    assign nxt = imm_mode ? imm_res : reg_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            op2       <= '0;
            carry_out <= 1'b0;
            live_q    <= 1'b0;
        end else begin
            op2       <= nxt.value;
            carry_out <= nxt.carry;
            live_q    <= 1'b1;
        end
    end

    AST_ZERO_AMT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(imm_mode) && $past(amt_sel) == '0)
        |-> (op2 == $past(reg_val) && carry_out == $past(carry_in)))
        else $error("zero amount altered operand"); // R6

    AST_IMM_NOROT_PASS: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(imm_mode) && $past(imm_field[FW-1:VW]) == '0)
        |-> (op2 == W'($past(imm_field[VW-1:0])) && carry_out == $past(carry_in)))
        else $error("unrotated constant mismatch"); // R11

    AST_LSL_WIDE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(imm_mode) && $past(shift_kind) == SHK_LSL
         && $past(amt_sel) >= AW'(W))
        |-> (op2 == '0))
        else $error("wide left shift left bits set"); // R8

    AST_ASR_WIDE_SIGN: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(imm_mode) && $past(shift_kind) == SHK_ASR
         && $past(amt_sel) >= AW'(W))
        |-> (op2 == {W{$past(reg_val[W-1])}} && carry_out == $past(reg_val[W-1])))
        else $error("wide arithmetic shift not sign filled"); // R9

    AST_ROR_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(imm_mode) && $past(shift_kind) == SHK_ROR)
        |-> ($countones(op2) == $countones($past(reg_val))))
        else $error("rotation changed set-bit count"); // R5

endmodule

// File: tb/tb_op2_shifter.sv
`timescale 1ns/1ps
module tb_op2_shifter;

    localparam int W    = 32;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        imm_mode;
    logic [11:0] imm_field;
    logic [31:0] reg_val;
    logic [1:0]  shift_kind;
    logic        amt_from_reg;
    logic [4:0]  amt_imm;
    logic [31:0] amt_reg;
    logic        carry_in;
    logic [31:0] op2;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(HALF) clk = ~clk;

    op2_shifter dut (
        .clk          (clk),
        .rst          (rst),
        .imm_mode     (imm_mode),
        .imm_field    (imm_field),
        .reg_val      (reg_val),
        .shift_kind   (shift_kind),
        .amt_from_reg (amt_from_reg),
        .amt_imm      (amt_imm),
        .amt_reg      (amt_reg),
        .carry_in     (carry_in),
        .op2          (op2),
        .carry_out    (carry_out)
    );

    // bit-serial reference: move one position per step, remember last bit out
    function automatic logic [32:0] model(
        input logic im, input logic [11:0] fld, input logic [31:0] rv,
        input logic [1:0] kd, input logic src, input logic [4:0] ai,
        input logic [31:0] ar, input logic ci);
        logic [31:0] v;
        logic        c;
        int          n;
        c = ci;
        if (im) begin
            v = {24'd0, fld[7:0]};
            n = 2 * int'(fld[11:8]);
            for (int i = 0; i < n; i++) begin
                c = v[0];
                v = {v[0], v[31:1]};
            end
            if (n == 0) c = ci;
        end else begin
            v = rv;
            n = src ? int'(ar[7:0]) : int'(ai);
            for (int i = 0; i < n; i++) begin
                case (kd)
                    2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
                    2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
                    2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
                    default: begin c = v[0]; v = {v[0], v[31:1]}; end
                endcase
            end
        end
        return {c, v};
    endfunction

    function automatic string reg_tag(input logic [1:0] kd, input int n, input logic src);
        if (n == 0)             return "R6";
        if (kd == 2'b11)        return "R5";
        if (n >= 32 && kd == 2'b10) return "R9";
        if (n >= 32)            return "R8";
        if (src)                return (kd == 2'b00) ? "R2/R7" : (kd == 2'b01) ? "R3/R7" : "R4/R7";
        return (kd == 2'b00) ? "R2" : (kd == 2'b01) ? "R3" : "R4";
    endfunction

    task automatic run_vec(input logic im, input logic [11:0] fld, input logic [31:0] rv,
                           input logic [1:0] kd, input logic src, input logic [4:0] ai,
                           input logic [31:0] ar, input logic ci, input string tag);
        logic [32:0] exp_v;
        @(negedge clk);
        imm_mode = im; imm_field = fld; reg_val = rv; shift_kind = kd;
        amt_from_reg = src; amt_imm = ai; amt_reg = ar; carry_in = ci;
        exp_v = model(im, fld, rv, kd, src, ai, ar, ci);
        @(posedge clk);
        #(HALF/2);
        checks++;
        if ({carry_out, op2} !== exp_v) begin
            fails++;
            $display("FAIL %s: actual op2=%h c=%b expected op2=%h c=%b",
                     tag, op2, carry_out, exp_v[31:0], exp_v[32]);
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6];
        int          amts [6];
        logic [31:0] seed;
        pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'hFFFF_FFFF; pats[4] = 32'h1234_5678; pats[5] = 32'h0000_0000;
        amts[0] = 0; amts[1] = 1; amts[2] = 31; amts[3] = 32; amts[4] = 33; amts[5] = 255;
        seed = 32'h1BADF00D;

        // R1: reset state with busy inputs
        rst = 1'b1;
        imm_mode = 1'b1; imm_field = 12'h4FF; reg_val = '1; shift_kind = 2'b11;
        amt_from_reg = 1'b0; amt_imm = 5'd3; amt_reg = '1; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        #(HALF/2);
        checks++;
        if (op2 !== 32'd0 || carry_out !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual op2=%h c=%b expected op2=00000000 c=0", op2, carry_out);
        end
        @(negedge clk);
        rst = 1'b0;

        // R10 named examples
        run_vec(1'b1, 12'h4FF, 32'h0, 2'b00, 1'b0, 5'd0, 32'h0, 1'b0, "R10");
        run_vec(1'b1, 12'hF01, 32'h0, 2'b00, 1'b0, 5'd0, 32'h0, 1'b1, "R10");

        // register mode sweep, amount from the register byte with junk above it
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 6; a++)
                for (int p = 0; p < 6; p++)
                    for (int c = 0; c < 2; c++)
                        run_vec(1'b0, 12'hABC, pats[p], 2'(k), 1'b1, 5'd17,
                                {24'hC3C3C3 ^ 24'(p), 8'(amts[a])}, 1'(c),
                                reg_tag(2'(k), amts[a], 1'b1));

        // immediate amount source, every 5-bit amount
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 32; a++) begin
                seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
                run_vec(1'b0, 12'h000, seed, 2'(k), 1'b0, 5'(a), 32'hFFFF_FF00 | 32'(a ^ 7),
                        seed[3], reg_tag(2'(k), a, 1'b0));
            end

        // R7: high bits of amount register have no effect
        run_vec(1'b0, 12'h0, 32'h8000_00F0, 2'b01, 1'b1, 5'd0, 32'hFFFF_FF04, 1'b0, "R7");
        run_vec(1'b0, 12'h0, 32'h8000_00F0, 2'b01, 1'b1, 5'd0, 32'h0000_0004, 1'b0, "R7");

        // R10 R11 R12: every immediate encoding with scrambled register-mode inputs
        for (int f = 0; f < 4096; f++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            run_vec(1'b1, 12'(f), seed, seed[9:8], seed[4], seed[14:10], ~seed, seed[2],
                    (f < 256) ? "R11/R12" : "R10/R11/R12");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule